// File: doc/BRIEF.md
# Converter Power and Clock-Mode Controller

This block decides whether a serial analog-to-digital converter is running or asleep, and which clock drives its conversions. The interface sequencer sends it a one-cycle start event together with the two power/clock bits from each control byte. It also passes on a flag that is high while a conversion is running. A three-level shutdown input arrives pre-encoded on two wires. From these the block drives the power state, the conversion clock source, a ready flag and the reference-buffer compensation choice. When a hardware shutdown cuts a running conversion short, it also sends the sequencer a one-cycle abort request.

Software power-down waits for the running conversion to finish, and the next start event wakes the block again. The shutdown pin acts at once and overrides the software bits. Each wake-up reloads a counter with a delay given in system-clock cycles, and the ready flag stays low until that counter runs out. All outputs are registered.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: After synchronous reset with the shutdown input not low, `pwr_state` is on (2'b00), `clk_ext` is 0, `abort` is 0 and `ready` is 0. `ready` rises exactly POR_CYC clock edges after the last edge at which `rst` was sampled high.
- R2: A start event with `pd_bits[1]`=1 sets `clk_ext` to `pd_bits[0]` (0 internal, 1 external) at the next edge and leaves an active, ready block on and ready.
- R3: A start event with `pd_bits[1]`=0 leaves `pwr_state` and `clk_ext` unchanged while the conversion runs. At the edge that first samples `conv_busy` low after it was high, `pwr_state` becomes fast power-down (2'b01) if `pd_bits[0]`=1, or full power-down (2'b10) if it was 0, and `ready` drops.
- R4: A start event while in either software power-down state returns `pwr_state` to on at the next edge with `ready` low. With the shutdown input high, `ready` then rises DLY_FAST edges later when waking from fast power-down, or DLY_FULL edges later when waking from full power-down.
- R5: A wake-up start event with `pd_bits[1]`=0 powers the block down again once that conversion ends. A wake-up start event with `pd_bits[1]`=1 keeps it on after `conv_busy` falls.
- R6: `shdn_lvl`=2'b00 (low) forces full power-down and `ready` low at the next edge, regardless of the control bits or a running conversion. Any pending software power-down request is dropped.
- R7: `abort` is high for exactly one cycle, the cycle after the edge that first samples `shdn_lvl` low while `conv_busy` is high. If `conv_busy` is low at that edge, `abort` stays low.
- R8: Start events sampled while the shutdown input is low change neither `pwr_state` nor `clk_ext`.
- R9: `comp_ext` is 1 after an edge sampling `shdn_lvl`=2'b10 or 2'b11 (floating), 0 after an edge sampling 2'b01 (high), and holds while the input is low. Leaving shutdown turns the block on at the next edge, and `ready` rises DLY_EXT edges later if floating, or DLY_FULL edges later if high.
- R10: When the shutdown input goes low in the same cycle as a start event or as the end of a conversion with a power-down pending, the block enters full power-down and the other event has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle start-bit event from the sequencer |
| pd_bits | input | 2 | Power/clock bits of the control byte, valid with `start_evt` |
| conv_busy | input | 1 | High while a conversion runs |
| shdn_lvl | input | 2 | Shutdown level: 00 low, 01 high, 1x floating |
| pwr_state | output | 2 | 00 on, 01 fast power-down, 10 full power-down |
| clk_ext | output | 1 | Conversion clock: 0 internal, 1 external |
| abort | output | 1 | One-cycle request to stop the running conversion |
| ready | output | 1 | Powered, and the power-up delay has elapsed |
| comp_ext | output | 1 | Reference-buffer compensation: 1 external, 0 internal |

## Verification
Shutdown and software control can fall in the same cycle. The bench drives `shdn_lvl` low at the same edge as a start event that asks for external clocking. It also drives `shdn_lvl` low at the same edge as the end of a conversion that has a fast power-down pending. Both cases must end in full power-down. The clock mode must stay unchanged, no abort may appear when no conversion was running, and the wake delay after release must be the full one. A separate check confirms that a power-down request pending when shutdown arrives is gone after release.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'b00,
    PWR_FAST = 2'b01,
    PWR_FULL = 2'b10
  } pwr_e;

  localparam logic [1:0] SHDN_LOW  = 2'b00;
  localparam logic [1:0] SHDN_HIGH = 2'b01;
endpackage

// File: rtl/adc_shdn_dec.sv
module adc_shdn_dec
  import adc_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] shdn_lvl,
  input  logic       conv_busy,
  output logic       hw_low,
  output logic       comp_float,
  output logic       hw_off_q,
  output logic       abort_q,
  output logic       comp_ext_q
);
  assign hw_low     = (shdn_lvl == SHDN_LOW);
  assign comp_float = shdn_lvl[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hw_off_q   <= hw_low;
      abort_q    <= 1'b0;
      comp_ext_q <= comp_float;
    end else begin
      hw_off_q <= hw_low;
      abort_q  <= hw_low && !hw_off_q && conv_busy;
      if (!hw_low) comp_ext_q <= comp_float;
    end
  end
endmodule

// File: rtl/adc_pwrup_timer.sv
module adc_pwrup_timer #(
  parameter int CW      = 8,
  parameter int POR_CYC = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic [CW-1:0] val,
  output logic          rdy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(POR_CYC);
      rdy <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (load) begin
      cnt <= val;
      rdy <= 1'b0;
    end else if (cnt > CW'(1)) begin
      cnt <= cnt - CW'(1);
    end else if (cnt == CW'(1)) begin
      cnt <= '0;
      rdy <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_pwr_fsm.sv
module adc_pwr_fsm
  import adc_pwr_pkg::*;
#(
  parameter int CW       = 8,
  parameter int DLY_FAST = 10,
  parameter int DLY_FULL = 60,
  parameter int DLY_EXT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_evt,
  input  logic [1:0]    pd_bits,
  input  logic          conv_busy,
  input  logic          hw_low,
  input  logic          hw_off_q,
  input  logic          comp_now,
  output pwr_e          st,
  output logic          clk_ext,
  output logic          tmr_load,
  output logic          tmr_clear,
  output logic [CW-1:0] tmr_val
);
  pwr_e st_n, kind, kind_n;
  logic mode_n, pend, pend_n, busy_q;

  always_comb begin
    st_n      = st;
    mode_n    = clk_ext;
    pend_n    = pend;
    kind_n    = kind;
    tmr_load  = 1'b0;
    tmr_clear = 1'b0;
    tmr_val   = '0;
    if (hw_low) begin
      st_n      = PWR_FULL;
      pend_n    = 1'b0;
      tmr_clear = 1'b1;
    end else if (hw_off_q) begin
      st_n     = PWR_ON;
      tmr_load = 1'b1;
      tmr_val  = comp_now ? CW'(DLY_EXT) : CW'(DLY_FULL);
    end else if (start_evt) begin
      if (st != PWR_ON) begin
        st_n     = PWR_ON;
        tmr_load = 1'b1;
        if (comp_now)            tmr_val = CW'(DLY_EXT);
        else if (st == PWR_FULL) tmr_val = CW'(DLY_FULL);
        else                     tmr_val = CW'(DLY_FAST);
      end
      if (pd_bits[1]) begin
        mode_n = pd_bits[0];
        pend_n = 1'b0;
      end else begin
        pend_n = 1'b1;
        kind_n = pd_bits[0] ? PWR_FAST : PWR_FULL;
      end
    end else if (pend && busy_q && !conv_busy) begin
      st_n      = kind;
      pend_n    = 1'b0;
      tmr_clear = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= hw_low ? PWR_FULL : PWR_ON;
      clk_ext <= 1'b0;
      pend    <= 1'b0;
      kind    <= PWR_FULL;
      busy_q  <= 1'b0;
    end else begin
      st      <= st_n;
      clk_ext <= mode_n;
      pend    <= pend_n;
      kind    <= kind_n;
      busy_q  <= conv_busy;
    end
  end
endmodule

// File: rtl/adc_pwr_ctrl.sv
module adc_pwr_ctrl
  import adc_pwr_pkg::*;
#(
  parameter int POR_CYC  = 40,
  parameter int DLY_FAST = 10,
  parameter int DLY_FULL = 60,
  parameter int DLY_EXT  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_evt,
  input  logic [1:0] pd_bits,
  input  logic       conv_busy,
  input  logic [1:0] shdn_lvl,
  output logic [1:0] pwr_state,
  output logic       clk_ext,
  output logic       abort,
  output logic       ready,
  output logic       comp_ext
);
  localparam int MAX_A = (POR_CYC > DLY_FULL) ? POR_CYC : DLY_FULL;
  localparam int MAX_B = (DLY_FAST > DLY_EXT) ? DLY_FAST : DLY_EXT;
  localparam int MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_D + 1);

  logic hw_low, comp_float, hw_off_q;
  logic tmr_load, tmr_clear;
  logic [CW-1:0] tmr_val;
  pwr_e st;

  adc_shdn_dec u_dec (
    .clk(clk), .rst(rst), .shdn_lvl(shdn_lvl), .conv_busy(conv_busy),
    .hw_low(hw_low), .comp_float(comp_float), .hw_off_q(hw_off_q),
    .abort_q(abort), .comp_ext_q(comp_ext)
  );

  adc_pwr_fsm #(
    .CW(CW), .DLY_FAST(DLY_FAST), .DLY_FULL(DLY_FULL), .DLY_EXT(DLY_EXT)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_evt(start_evt), .pd_bits(pd_bits),
    .conv_busy(conv_busy), .hw_low(hw_low), .hw_off_q(hw_off_q),
    .comp_now(comp_float), .st(st), .clk_ext(clk_ext),
    .tmr_load(tmr_load), .tmr_clear(tmr_clear), .tmr_val(tmr_val)
  );

  adc_pwrup_timer #(.CW(CW), .POR_CYC(POR_CYC)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .clear(tmr_clear),
    .val(tmr_val), .rdy(ready)
  );

  assign pwr_state = st;
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
module adc_pwr_ctrl_chk
  import adc_pwr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       start_evt,
  input logic       conv_busy,
  input logic [1:0] shdn_lvl,
  input logic [1:0] pwr_state,
  input logic       clk_ext,
  input logic       abort,
  input logic       ready,
  input logic       comp_ext
);
  AST_SHDN_FORCES_FULL: assert property (@(posedge clk) disable iff (rst)
    shdn_lvl == SHDN_LOW |=> pwr_state == PWR_FULL && !ready); // R6
  AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort); // R7
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(conv_busy) && $past(shdn_lvl) == SHDN_LOW); // R7
  AST_READY_ONLY_ON: assert property (@(posedge clk) disable iff (rst)
    ready |-> pwr_state == PWR_ON); // R4
  AST_MODE_HELD_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    pwr_state != PWR_ON |-> $stable(clk_ext)); // R8
  AST_COMP_INTERNAL: assert property (@(posedge clk) disable iff (rst)
    shdn_lvl == SHDN_HIGH |=> !comp_ext); // R9
  AST_START_IGNORED_LOW: assert property (@(posedge clk) disable iff (rst)
    start_evt && shdn_lvl == SHDN_LOW |=> pwr_state == PWR_FULL); // R10
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .start_evt(start_evt), .conv_busy(conv_busy),
  .shdn_lvl(shdn_lvl), .pwr_state(pwr_state), .clk_ext(clk_ext),
  .abort(abort), .ready(ready), .comp_ext(comp_ext)
);

// File: tb/tb_adc_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_adc_pwr_ctrl;
  localparam int POR  = 40;
  localparam int FAST = 10;
  localparam int FULL = 60;
  localparam int EXT  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_evt = 1'b0;
  logic [1:0] pd_bits = 2'b00;
  logic conv_busy = 1'b0;
  logic [1:0] shdn_lvl = 2'b01;
  logic [1:0] pwr_state;
  logic clk_ext, abort, ready, comp_ext;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  adc_pwr_ctrl #(.POR_CYC(POR), .DLY_FAST(FAST), .DLY_FULL(FULL), .DLY_EXT(EXT)) dut (
    .clk(clk), .rst(rst), .start_evt(start_evt), .pd_bits(pd_bits),
    .conv_busy(conv_busy), .shdn_lvl(shdn_lvl), .pwr_state(pwr_state),
    .clk_ext(clk_ext), .abort(abort), .ready(ready), .comp_ext(comp_ext)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send_start(input logic [1:0] pd);
    start_evt = 1'b1;
    pd_bits   = pd;
    tick();
    start_evt = 1'b0;
  endtask

  task automatic busy_pulse();
    conv_busy = 1'b1;
    tick();
    conv_busy = 1'b0;
    tick();
  endtask

  task automatic wait_ready(input int d, input string req);
    repeat (d - 1) tick();
    check(req, "ready before delay", int'(ready), 0);
    tick();
    check(req, "ready after delay", int'(ready), 1);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    tick();
    rst = 1'b0;
    check("R1", "state", int'(pwr_state), 0);
    check("R1", "clk_ext", int'(clk_ext), 0);
    check("R1", "ready", int'(ready), 0);
    check("R1", "abort", int'(abort), 0);
    wait_ready(POR, "R1");
  endtask

  task automatic t_mode();
    send_start(2'b11);
    check("R2", "ext mode", int'(clk_ext), 1);
    check("R2", "ready kept", int'(ready), 1);
    send_start(2'b10);
    check("R2", "int mode", int'(clk_ext), 0);
    send_start(2'b11);
    check("R2", "state on", int'(pwr_state), 0);
  endtask

  task automatic t_swpd();
    send_start(2'b01);
    conv_busy = 1'b1;
    repeat (3) tick();
    check("R3", "on while busy", int'(pwr_state), 0);
    check("R3", "mode held", int'(clk_ext), 1);
    conv_busy = 1'b0;
    tick();
    check("R3", "fast pd", int'(pwr_state), 1);
    check("R3", "ready low", int'(ready), 0);
    send_start(2'b00);
    check("R4", "woken", int'(pwr_state), 0);
    check("R4", "mode kept", int'(clk_ext), 1);
    wait_ready(FAST, "R4");
    busy_pulse();
    check("R5", "repowered down full", int'(pwr_state), 2);
    send_start(2'b10);
    check("R4", "woken from full", int'(pwr_state), 0);
    check("R2", "int on wake", int'(clk_ext), 0);
    wait_ready(FULL, "R4");
    busy_pulse();
    check("R5", "stays on", int'(pwr_state), 0);
    check("R5", "stays ready", int'(ready), 1);
  endtask

  task automatic t_hw_abort();
    conv_busy = 1'b1;
    tick();
    shdn_lvl = 2'b00;
    tick();
    check("R7", "abort pulse", int'(abort), 1);
    check("R6", "full pd", int'(pwr_state), 2);
    check("R6", "ready low", int'(ready), 0);
    tick();
    check("R7", "abort one cycle", int'(abort), 0);
    conv_busy = 1'b0;
    send_start(2'b11);
    check("R8", "start ignored", int'(pwr_state), 2);
    tick();
    shdn_lvl = 2'b10;
    tick();
    check("R9", "released on", int'(pwr_state), 0);
    check("R9", "comp ext", int'(comp_ext), 1);
    check("R8", "mode unchanged", int'(clk_ext), 0);
    wait_ready(EXT, "R9");
    shdn_lvl = 2'b01;
    tick();
    check("R9", "comp int", int'(comp_ext), 0);
  endtask

  task automatic t_hw_pending();
    send_start(2'b01);
    conv_busy = 1'b1;
    tick();
    shdn_lvl = 2'b00;
    tick();
    check("R7", "abort pending case", int'(abort), 1);
    conv_busy = 1'b0;
    tick();
    check("R9", "comp held low", int'(comp_ext), 0);
    shdn_lvl = 2'b01;
    tick();
    check("R9", "on after high", int'(pwr_state), 0);
    wait_ready(FULL, "R9");
    busy_pulse();
    check("R6", "pending dropped", int'(pwr_state), 0);
    shdn_lvl = 2'b00;
    tick();
    check("R7", "no abort idle", int'(abort), 0);
    check("R6", "idle full pd", int'(pwr_state), 2);
    shdn_lvl = 2'b01;
    tick();
    wait_ready(FULL, "R6");
  endtask

  task automatic t_collide();
    send_start(2'b01);
    conv_busy = 1'b1;
    tick();
    conv_busy = 1'b0;
    shdn_lvl  = 2'b00;
    tick();
    check("R10", "shdn beats sw pd", int'(pwr_state), 2);
    check("R10", "no abort", int'(abort), 0);
    shdn_lvl = 2'b01;
    tick();
    wait_ready(FULL, "R10");
    shdn_lvl  = 2'b00;
    start_evt = 1'b1;
    pd_bits   = 2'b11;
    tick();
    start_evt = 1'b0;
    check("R10", "shdn beats start", int'(pwr_state), 2);
    check("R10", "mode not taken", int'(clk_ext), 0);
    shdn_lvl = 2'b01;
    tick();
    check("R10", "on after release", int'(pwr_state), 0);
    wait_ready(FULL, "R10");
  endtask

  initial begin
    t_reset();
    t_mode();
    t_swpd();
    t_hw_abort();
    t_hw_pending();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule